// File: doc/BRIEF.md
# Peak-Current PWM Cycle Controller

This block is the digital timing core of a peak-current-mode switching converter. It runs a switching period counted in clock cycles and drives a gate request high at the start of each period. The pulse ends on the first of several events: the main current-sense comparator trips, a separate over-power comparator trips, the duty limit is reached, or the skip request is active. Both current comparator inputs are ignored for a blanking window after turn-on, and that window scales with the current period length. The period length follows a slow triangular dither around its nominal value to spread the switching spectrum.

Alongside the gate, the block produces a current setpoint code for an external DAC. The code is one third of the feedback code. It is limited by a soft-start ramp that climbs from zero to a fixed ceiling after enable, and then by the ceiling itself. An error flag reports that feedback is demanding at least the ceiling. Deasserting the enable forces the gate low, restarts the period and restarts the soft-start ramp.

Top module: `pcm_cycle_ctrl`

## Requirements
- R1: While reset is asserted, gate_o, setpoint_o, err_flag_o and cycle_start_o are all 0.
- R2: The gate rises only on the clock edge at which cycle_start_o is 1, at most once per period, and only if skip_i is 0 at that edge.
- R3: Once past blanking, cs_trip_i or opl_trip_i high while the gate is high drives the gate low on that edge, and the gate stays low for the rest of the period; either input alone suffices.
- R4: With period length P, comparator trips are ignored while the period count is at most floor(P*27/1000), which covers the first blanking cycles of the pulse.
- R5: A pulse lasts at most floor(P*80/100) cycles; at that count the gate is forced low.
- R6: skip_i high at period start suppresses the pulse; skip_i high during a pulse ends it on the next edge, without blanking.
- R7: cycle_start_o is 1 in the first cycle of each period (count 0, enable high). Period length starts at PERIOD_NOM and changes by one cycle per period in a triangle between PERIOD_NOM-D and PERIOD_NOM+D, with D = floor(PERIOD_NOM*35/1000), first rising.
- R8: setpoint_o equals the minimum of floor(fb_code_i/3) and the soft-start limit, registered one cycle after fb_code_i is applied.
- R9: After enable, the soft-start limit starts at 0 and rises by 1 every floor(SS_CYCLES/SP_CEIL) cycles until it reaches SP_CEIL, then it holds.
- R10: err_flag_o is 1 one cycle after an enabled cycle with floor(fb_code_i/3) >= SP_CEIL, and 0 otherwise.
- R11: en_i low forces the gate low, setpoint_o and err_flag_o to 0 on the next edge, resets the period count and the soft-start limit, and holds the dither position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; low forces gate off and restarts |
| fb_code_i | input | FB_W | Feedback code |
| cs_trip_i | input | 1 | Sense current above setpoint |
| opl_trip_i | input | 1 | Over-power comparator trip |
| skip_i | input | 1 | Feedback below skip level |
| gate_o | output | 1 | Gate drive request |
| setpoint_o | output | SP_W | Current setpoint code for the DAC |
| err_flag_o | output | 1 | Setpoint demand at or above the ceiling |
| cycle_start_o | output | 1 | First cycle of a switching period |

## Verification
gate_o, setpoint_o and err_flag_o each pass through a single register. Their response to the inputs and to the period count present in one cycle appears after the next rising edge. cycle_start_o is decoded from the count register and the live enable, so it is valid in the same cycle. The bench drives inputs just after a falling edge and reads cycle_start_o one time step later. It advances a behavioural model by one step and compares the registered outputs at the following falling edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic {
    DITH_UP   = 1'b0,
    DITH_DOWN = 1'b1
  } dith_dir_e;
endpackage

// File: rtl/pcm_period_gen.sv
module pcm_period_gen
  import pcm_pkg::*;
#(
  parameter int PERIOD_NOM    = 200,
  parameter int DITHER_PERMIL = 35,
  parameter int DUTY_PCT      = 80,
  parameter int BLANK_PERMIL  = 27,
  localparam int DMAX = (PERIOD_NOM * DITHER_PERMIL) / 1000,
  localparam int PMAX = PERIOD_NOM + DMAX,
  localparam int CW   = $clog2(PMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] max_on_o,
  output logic [CW-1:0] blank_o,
  output logic          start_o
);
  localparam int IW = $clog2(2 * DMAX + 2);
  localparam int PW = CW + 10;

  logic [CW-1:0] cnt_q, cnt_d, period;
  logic [IW-1:0] idx_q, idx_d;
  dith_dir_e     dir_q, dir_d;
  logic          wrap;
  logic [PW-1:0] duty_prod, blank_prod;

  // current period from dither index; limits scale with it
  always_comb begin
    period     = CW'(PERIOD_NOM - DMAX) + CW'(idx_q);
    wrap       = (cnt_q == period - CW'(1));
    duty_prod  = PW'(period) * PW'(DUTY_PCT);
    blank_prod = PW'(period) * PW'(BLANK_PERMIL);
    max_on_o   = CW'(duty_prod / PW'(100));
    blank_o    = CW'(blank_prod / PW'(1000));
    cnt_o      = cnt_q;
    start_o    = en_i && (cnt_q == '0);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  generate
    if (DMAX > 0) begin : g_dither
      always_comb begin
        idx_d = idx_q;
        dir_d = dir_q;
        if (en_i && wrap) begin
          if (dir_q == DITH_UP) begin
            if (idx_q == IW'(2 * DMAX)) begin
              dir_d = DITH_DOWN;
              idx_d = idx_q - IW'(1);
            end else begin
              idx_d = idx_q + IW'(1);
            end
          end else begin
            if (idx_q == '0) begin
              dir_d = DITH_UP;
              idx_d = idx_q + IW'(1);
            end else begin
              idx_d = idx_q - IW'(1);
            end
          end
        end
      end
    end else begin : g_fixed
      always_comb begin
        idx_d = idx_q;
        dir_d = dir_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= IW'(DMAX);
      dir_q <= DITH_UP;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/pcm_setpoint.sv
module pcm_setpoint #(
  parameter int FB_W      = 10,
  parameter int SP_W      = 8,
  parameter int SP_CEIL   = 180,
  parameter int SS_CYCLES = 1800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [FB_W-1:0] fb_code_i,
  output logic [SP_W-1:0] setpoint_o,
  output logic            err_o
);
  localparam int SS_STEP = (SS_CYCLES / SP_CEIL) > 0 ? (SS_CYCLES / SP_CEIL) : 1;
  localparam int DW      = $clog2(SS_STEP + 1);

  logic [SP_W-1:0] ss_q, ss_d, sp_q, sp_d;
  logic [DW-1:0]   div_q, div_d;
  logic            err_q, err_d;
  logic [FB_W-1:0] raw, ss_ext;

  always_comb begin
    raw    = fb_code_i / FB_W'(3);
    ss_ext = FB_W'(ss_q);
    sp_d   = '0;
    err_d  = 1'b0;
    if (en_i) begin
      sp_d  = (raw < ss_ext) ? SP_W'(raw) : ss_q;
      err_d = (raw >= FB_W'(SP_CEIL));
    end
  end

  // soft-start ramp: one step every SS_STEP enabled cycles
  always_comb begin
    ss_d  = ss_q;
    div_d = div_q;
    if (!en_i) begin
      ss_d  = '0;
      div_d = '0;
    end else if (ss_q < SP_W'(SP_CEIL)) begin
      if (div_q == DW'(SS_STEP - 1)) begin
        div_d = '0;
        ss_d  = ss_q + SP_W'(1);
      end else begin
        div_d = div_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q  <= '0;
      div_q <= '0;
      sp_q  <= '0;
      err_q <= 1'b0;
    end else begin
      ss_q  <= ss_d;
      div_q <= div_d;
      sp_q  <= sp_d;
      err_q <= err_d;
    end
  end

  assign setpoint_o = sp_q;
  assign err_o      = err_q;
endmodule

// File: rtl/pcm_gate_ctl.sv
module pcm_gate_ctl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] max_on_i,
  input  logic [CW-1:0] blank_i,
  input  logic          cs_trip_i,
  input  logic          opl_trip_i,
  input  logic          skip_i,
  output logic          gate_o
);
  logic gate_q, gate_d;
  logic past_blank, end_evt;

  always_comb begin
    past_blank = (cnt_i > blank_i);
    end_evt    = skip_i || (cnt_i >= max_on_i) ||
                 (past_blank && (cs_trip_i || opl_trip_i));
    gate_d     = gate_q;
    if (!en_i)                gate_d = 1'b0;
    else if (cnt_i == '0)     gate_d = !skip_i;
    else if (gate_q && end_evt) gate_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/pcm_cycle_ctrl.sv
module pcm_cycle_ctrl #(
  parameter int PERIOD_NOM    = 200,
  parameter int DITHER_PERMIL = 35,
  parameter int DUTY_PCT      = 80,
  parameter int BLANK_PERMIL  = 27,
  parameter int FB_W          = 10,
  parameter int SP_W          = 8,
  parameter int SP_CEIL       = 180,
  parameter int SS_CYCLES     = 1800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [FB_W-1:0] fb_code_i,
  input  logic            cs_trip_i,
  input  logic            opl_trip_i,
  input  logic            skip_i,
  output logic            gate_o,
  output logic [SP_W-1:0] setpoint_o,
  output logic            err_flag_o,
  output logic            cycle_start_o
);
  localparam int DMAX = (PERIOD_NOM * DITHER_PERMIL) / 1000;
  localparam int CW   = $clog2(PERIOD_NOM + DMAX + 1);

  logic [CW-1:0] cnt, max_on, blank;

  pcm_period_gen #(
    .PERIOD_NOM   (PERIOD_NOM),
    .DITHER_PERMIL(DITHER_PERMIL),
    .DUTY_PCT     (DUTY_PCT),
    .BLANK_PERMIL (BLANK_PERMIL)
  ) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .cnt_o   (cnt),
    .max_on_o(max_on),
    .blank_o (blank),
    .start_o (cycle_start_o)
  );

  pcm_gate_ctl #(.CW(CW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .cnt_i     (cnt),
    .max_on_i  (max_on),
    .blank_i   (blank),
    .cs_trip_i (cs_trip_i),
    .opl_trip_i(opl_trip_i),
    .skip_i    (skip_i),
    .gate_o    (gate_o)
  );

  pcm_setpoint #(
    .FB_W     (FB_W),
    .SP_W     (SP_W),
    .SP_CEIL  (SP_CEIL),
    .SS_CYCLES(SS_CYCLES)
  ) u_setpoint (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .fb_code_i (fb_code_i),
    .setpoint_o(setpoint_o),
    .err_o     (err_flag_o)
  );
endmodule

// File: rtl/pcm_cycle_ctrl_chk.sv
module pcm_cycle_ctrl_chk #(
  parameter int PERIOD_NOM    = 200,
  parameter int DITHER_PERMIL = 35,
  parameter int DUTY_PCT      = 80,
  parameter int SP_W          = 8,
  parameter int SP_CEIL       = 180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic            skip_i,
  input logic            gate_o,
  input logic [SP_W-1:0] setpoint_o,
  input logic            cycle_start_o
);
  localparam int PMAX  = PERIOD_NOM + (PERIOD_NOM * DITHER_PERMIL) / 1000;
  localparam int ONMAX = (PMAX * DUTY_PCT) / 100;

  logic [15:0] on_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      on_run <= '0;
    else if (gate_o) on_run <= on_run + {15'd0, (on_run != 16'hFFFF)};
    else             on_run <= '0;
  end

  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(cycle_start_o));

  a_r5_duty_bound: assert property (@(posedge clk) disable iff (!rst_n)
    on_run <= 16'(ONMAX));

  a_r6_skip_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start_o && skip_i) |=> !gate_o);

  a_r11_disable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !gate_o);

  a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    setpoint_o <= SP_W'(SP_CEIL));
endmodule

bind pcm_cycle_ctrl pcm_cycle_ctrl_chk #(
  .PERIOD_NOM   (PERIOD_NOM),
  .DITHER_PERMIL(DITHER_PERMIL),
  .DUTY_PCT     (DUTY_PCT),
  .SP_W         (SP_W),
  .SP_CEIL      (SP_CEIL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .skip_i       (skip_i),
  .gate_o       (gate_o),
  .setpoint_o   (setpoint_o),
  .cycle_start_o(cycle_start_o)
);

// File: tb/test_pcm_cycle_ctrl.sv
module test_pcm_cycle_ctrl;
  localparam int NOM   = 200;
  localparam int DITH  = 35;
  localparam int DUTY  = 80;
  localparam int BLNK  = 27;
  localparam int FBW   = 10;
  localparam int SPW   = 8;
  localparam int CEIL  = 180;
  localparam int SSCYC = 1800;
  localparam int DM    = NOM * DITH / 1000;
  localparam int STEP  = SSCYC / CEIL;
  localparam int NCYC  = 18000;

  logic clk = 1'b0;
  logic rst_n, en, cs, opl, skip;
  logic [FBW-1:0] fb;
  logic gate, err, cstart;
  logic [SPW-1:0] sp;

  always #10 clk = ~clk;

  pcm_cycle_ctrl #(
    .PERIOD_NOM(NOM), .DITHER_PERMIL(DITH), .DUTY_PCT(DUTY), .BLANK_PERMIL(BLNK),
    .FB_W(FBW), .SP_W(SPW), .SP_CEIL(CEIL), .SS_CYCLES(SSCYC)
  ) i_pcm_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .fb_code_i(fb), .cs_trip_i(cs),
    .opl_trip_i(opl), .skip_i(skip), .gate_o(gate), .setpoint_o(sp),
    .err_flag_o(err), .cycle_start_o(cstart)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_cnt, m_idx, m_up, m_gate, m_ss, m_div, m_sp, m_err;
  string g_tag, s_tag;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic model_step();
    int p, maxon, blank, raw, ng, ncnt, nsp, nerr, nss, ndiv;
    p     = NOM - DM + m_idx;
    maxon = p * DUTY / 100;
    blank = p * BLNK / 1000;
    raw   = int'(fb) / 3;
    ng = m_gate; ncnt = m_cnt; nss = m_ss; ndiv = m_div;
    g_tag = "R2 gate";
    if (!en) begin
      ng = 0; ncnt = 0; nss = 0; ndiv = 0; nsp = 0; nerr = 0;
      g_tag = "R11 gate";
      s_tag = "R11 setpoint";
    end else begin
      if (m_cnt == 0) begin
        ng = skip ? 0 : 1;
        if (skip) g_tag = "R6 gate";
      end else if (m_gate == 1) begin
        if (skip) begin ng = 0; g_tag = "R6 gate"; end
        else if (m_cnt >= maxon) begin ng = 0; g_tag = "R5 gate"; end
        else if (m_cnt > blank && (cs || opl)) begin ng = 0; g_tag = "R3 gate"; end
        else if (cs || opl) g_tag = "R4 gate";
      end else if (cs || opl) g_tag = "R3 gate";
      nsp   = (raw < m_ss) ? raw : m_ss;
      nerr  = (raw >= CEIL) ? 1 : 0;
      s_tag = (raw > m_ss) ? "R9 setpoint" : "R8 setpoint";
      if (m_ss < CEIL) begin
        if (m_div == STEP - 1) begin ndiv = 0; nss = m_ss + 1; end
        else ndiv = m_div + 1;
      end
      if (m_cnt == p - 1) begin
        ncnt = 0;
        if (m_up == 1) begin
          if (m_idx == 2 * DM) begin m_up = 0; m_idx--; end else m_idx++;
        end else begin
          if (m_idx == 0) begin m_up = 1; m_idx++; end else m_idx--;
        end
      end else ncnt = m_cnt + 1;
    end
    m_gate = ng; m_cnt = ncnt; m_ss = nss; m_div = ndiv; m_sp = nsp; m_err = nerr;
  endtask

  task automatic drive(input int k);
    if (k < 2500) begin
      en = 1; fb = '1; cs = 0; opl = 0; skip = 0;
    end else begin
      if (k % 50 == 0) begin
        if ($urandom_range(3) == 0) fb = FBW'(3 * CEIL - 1 + $urandom_range(2));
        else                        fb = FBW'($urandom_range(1023));
      end
      cs  = ($urandom_range(11) == 0);
      opl = ($urandom_range(29) == 0);
      if (k >= 9000 && $urandom_range(149) == 0) skip = !skip;
      if (k >= 14000) begin
        if (en) en = ($urandom_range(399) != 0);
        else    en = ($urandom_range(19) == 0);
      end
    end
  endtask

  initial begin
    rst_n = 0; en = 0; fb = '0; cs = 0; opl = 0; skip = 0;
    m_cnt = 0; m_idx = DM; m_up = 1; m_gate = 0; m_ss = 0; m_div = 0; m_sp = 0; m_err = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 gate reset", int'(gate), 0);
      chk("R1 setpoint reset", int'(sp), 0);
      chk("R1 err reset", int'(err), 0);
      chk("R1 start reset", int'(cstart), 0);
    end
    rst_n = 1;
    for (int k = 0; k < NCYC; k++) begin
      drive(k);
      #1;
      chk("R7 cycle_start", int'(cstart), (en && m_cnt == 0) ? 1 : 0);
      model_step();
      @(negedge clk);
      chk(g_tag, int'(gate), m_gate);
      chk(s_tag, int'(sp), m_sp);
      chk("R10 err_flag", int'(err), m_err);
    end
    finish_run();
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule